// File: doc/BRIEF.md
# Oscillator Start-Up Delay Counter

This block holds the core's instruction clocks off for a fixed settling interval after the device wakes from a halted state. When a wakeup start strobe arrives, it drops the core-clock enable and loads a down counter with 256. It also clears a divide-by-five prescaler. The prescaler turns high-speed oscillator cycles into instruction-cycle ticks. It advances only in cycles where the amplitude-valid qualifier from the oscillator front end shows a usable swing.

Each tick decrements the counter. On the tick that takes the counter to zero, the block raises the core-clock enable and emits a one-cycle done pulse. The interval is therefore always 256 instruction cycles, which is 1280 qualified oscillator cycles. The clock-delay option bit does not shorten or skip it.

While the delay runs, the shared timer clock select points at the high-speed tick. Once the delay completes, the select returns to the low-speed clock.

Top module: `osc_startup_delay`

## Requirements
- R1: After reset, core_clk_en_o is 1, done_o is 0 and tmr_slow_sel_o is 1 (1 = shared timer on the low-speed clock).
- R2: A start_i sampled high at a clock edge loads the count with 256, clears the prescaler, and drives core_clk_en_o and tmr_slow_sel_o to 0 from that edge on.
- R3: Counting is by one instruction tick every 5 qualified cycles. The first tick falls on the fifth qualified edge after the start edge.
- R4: Edges at which amp_ok_i is 0 neither advance the prescaler nor change the count. With amp_ok_i held low, the delay never completes.
- R5: After the 256th tick, core_clk_en_o rises and done_o pulses at the same edge. That edge is the 1280th edge after the start edge at which amp_ok_i was 1.
- R6: delay_opt_i has no effect. The delay length is identical with it at 0 or 1.
- R7: done_o is high for exactly one cycle. core_clk_en_o then stays 1 until the next start_i.
- R8: tmr_slow_sel_o returns to 1 at the same edge that completes the delay.
- R9: A start_i during a running delay restarts it from the full 256-tick count with a cleared prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | High-speed oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Wakeup strobe that begins the delay |
| amp_ok_i | input | 1 | Oscillator amplitude-valid qualifier |
| delay_opt_i | input | 1 | Clock-delay option bit (no effect on delay) |
| core_clk_en_o | output | 1 | Instruction clock enable to the core |
| done_o | output | 1 | One-cycle pulse when the delay completes |
| tmr_slow_sel_o | output | 1 | Shared timer clock select, 1 = low-speed clock |

## Verification
A prescaler that is not cleared on start, or that counts unqualified cycles, shows up as done_o arriving earlier or later than the 1280th qualified edge. The bench measures that edge exactly for several amp_ok_i duty patterns. A count that is off by one shifts done_o by five qualified cycles, so it is caught at the first completion. A stuck busy state shows within the same window, as core_clk_en_o or tmr_slow_sel_o held wrong during or after the delay. A missed restart shows as a done pulse 1280 qualified edges after the first strobe rather than the second.

// File: rtl/sud_pkg.sv
package sud_pkg;
  parameter int unsigned PRE_DIV   = 5;
  parameter int unsigned START_CNT = 256;
  localparam int unsigned CNT_W = $clog2(START_CNT + 1);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
endpackage

// File: rtl/sud_prescaler.sv
module sud_prescaler #(
  parameter int unsigned DIV = sud_pkg::PRE_DIV,
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tick_o
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] pre_q;

  assign tick_o = adv_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (adv_i)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);                                             // R3
  AST_PRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);                                     // R9
endmodule

// File: rtl/sud_counter.sv
module sud_counter #(
  parameter int unsigned START = sud_pkg::START_CNT,
  localparam int unsigned W = $clog2(START + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] INIT = W'(START);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign last_o = dec_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= INIT;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  AST_LOAD_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == INIT);                                  // R2
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && cnt_q == '0 |=> cnt_q == '0);                    // R5
endmodule

// File: rtl/osc_startup_delay.sv
module osc_startup_delay #(
  parameter int unsigned PRE_DIV   = sud_pkg::PRE_DIV,
  parameter int unsigned START_CNT = sud_pkg::START_CNT,
  localparam int unsigned CNT_W = $clog2(START_CNT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic amp_ok_i,
  input  logic delay_opt_i,
  output logic core_clk_en_o,
  output logic done_o,
  output logic tmr_slow_sel_o
);
  logic             busy_q, en_q, done_q, slow_q;
  logic             adv, tick, last;
  logic [CNT_W-1:0] cnt;
  logic             unused_delay_opt;

  // delay is mandatory: option bit deliberately ignored
  assign unused_delay_opt = delay_opt_i;

  assign adv = busy_q && amp_ok_i && !start_i;

  sud_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .adv_i  (adv),
    .tick_o (tick)
  );

  sud_counter #(.START(START_CNT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .dec_i  (tick),
    .cnt_o  (cnt),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      en_q   <= 1'b1;
      done_q <= 1'b0;
      slow_q <= 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      slow_q <= 1'b0;
    end else if (last) begin
      busy_q <= 1'b0;
      en_q   <= 1'b1;
      done_q <= 1'b1;
      slow_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign core_clk_en_o  = en_q;
  assign done_o         = done_q;
  assign tmr_slow_sel_o = slow_q;

  AST_START_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !core_clk_en_o && !tmr_slow_sel_o);             // R2
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !amp_ok_i && !start_i |=> $stable(cnt) && !done_o); // R4
  AST_DONE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> core_clk_en_o && tmr_slow_sel_o);                // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                        // R7
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o && !start_i |=> core_clk_en_o);               // R7
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cnt == '0);                               // R5
endmodule

// File: tb/sim_osc_startup_delay.sv
module sim_osc_startup_delay;
  localparam int QUAL = 1280;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, amp_i = 1'b1, opt_i = 1'b0;
  logic en_o, done_o, sel_o;
  int   cyc = 0, mode = 0;
  int   checks = 0, errors = 0;
  int   exp_q[$];
  bit   prev_done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osc_startup_delay u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .amp_ok_i(amp_i),
    .delay_opt_i(opt_i), .core_clk_en_o(en_o), .done_o(done_o),
    .tmr_slow_sel_o(sel_o)
  );

  function automatic bit amp_f(int c, int m);
    case (m)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 3) != 0;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) amp_i = amp_f(cyc, mode);

  function automatic int exp_done(int s, int m);
    int n = 0;
    int e = s;
    while (n < QUAL) begin
      e++;
      if (amp_f(e - 1, m)) n++;
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(output int s);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; s = cyc;
  endtask

  task automatic wait_empty(string req);
    int n = 0;
    while (exp_q.size() > 0 && n < 6000) begin
      @(negedge clk); n++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // driver: start a delay and push the expected completion edge
  task automatic run_delay(int m, bit opt, string req);
    int s;
    mode = m; opt_i = opt;
    repeat (3) @(negedge clk);
    pulse_start(s);
    exp_q.push_back(exp_done(s, m));
    repeat (100) @(negedge clk);
    chk(en_o == 1'b0, "R2 enable low while delaying", en_o, 0);
    chk(sel_o == 1'b0, "R8 timer on fast clock while delaying", sel_o, 0);
    wait_empty(req);
    @(negedge clk);
    chk(en_o == 1'b1, "R7 enable held after done", en_o, 1);
    chk(sel_o == 1'b1, "R8 timer back on slow clock", sel_o, 1);
  endtask

  // monitor: compare each done pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected done", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R5 done edge", cyc, e);
          chk(en_o == 1'b1, "R5 enable with done", en_o, 1);
        end
        chk(!prev_done, "R7 done single cycle", prev_done, 0);
      end
      prev_done = done_o;
    end
  end

  initial begin
    #(4 * 190000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s, s2, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(en_o == 1'b1, "R1 reset enable", en_o, 1);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(sel_o == 1'b1, "R1 reset timer select", sel_o, 1);

    run_delay(0, 1'b0, "R3 full rate delay");
    run_delay(0, 1'b1, "R6 option bit set same delay");
    run_delay(1, 1'b0, "R4 half qualified");
    run_delay(2, 1'b1, "R4 two of three qualified");

    // R9: restart after a few cycles and mid-delay
    mode = 0; opt_i = 1'b0;
    pulse_start(s);
    repeat (2) @(negedge clk);
    pulse_start(s2);
    exp_q.delete();
    exp_q.push_back(exp_done(s2, 0));
    repeat (400) @(negedge clk);
    pulse_start(s2);
    exp_q.delete();
    exp_q.push_back(exp_done(s2, 0));
    wait_empty("R9 restart reloads");
    chk(s2 > s, "R9 restart order", s2, s);

    // R4: amplitude never valid freezes the delay
    mode = 3;
    repeat (3) @(negedge clk);
    pulse_start(s);
    repeat (3000) @(negedge clk);
    chk(en_o == 1'b0, "R4 frozen without amplitude", en_o, 0);
    chk(exp_q.size() == 0, "R4 no done while frozen", exp_q.size(), 0);
    @(posedge clk); #1;
    mode = 0; m = cyc;
    exp_q.push_back(m + QUAL);
    wait_empty("R4 resumes from full count");

    repeat (20) @(negedge clk);
    chk(en_o == 1'b1 && done_o == 1'b0, "R7 idle after done", en_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule